// File: doc/BRIEF.md
# Vector Pairwise Widening Add-Accumulate Unit

This block is the execution datapath for the vector pairwise add-long operations. Each adjacent pair of source elements (lanes 2e and 2e+1) is sign- or zero-extended to twice its width. The two extended values are added to form result lane e. In accumulate mode that sum is also added to lane e of the incoming destination vector. All arithmetic wraps at the result lane width.

The source element width is 8, 16 or 32 bits, selected by a 2-bit size field. A width bit chooses between a 64-bit and a 128-bit operation. In 64-bit operation the upper half of the result is forced to zero. Size code 3 is reserved: the unit raises an illegal-operation flag and passes the destination through unchanged.

The result is registered. A request presented with `in_valid` appears on the outputs one clock later, and the outputs hold their value until the next request.

Top module: `pairwise_widen_acc`

## Requirements
- R1: Size code 0, 1 and 2 selects 8-, 16- and 32-bit source elements, and the result lanes are 16, 32 and 64 bits wide.
- R2: Size code 3 is reserved. The unit asserts `illegal_op` and `res_vec` equals the full 128-bit `dst_vec` of that request.
- R3: With `wide_q`=1 all 128 source bits are reduced. With `wide_q`=0 only bits 63:0 are reduced, giving half as many result lanes.
- R4: Result lane e is the sum of source lanes 2e and 2e+1, each extended to result width. The extension is signed when `is_signed`=1 and zero-extended when it is 0.
- R5: With `do_accum`=1, lane e of `dst_vec` is added to the pair sum. With `do_accum`=0 it is ignored. All sums wrap modulo 2^(result lane width).
- R6: For a legal request with `wide_q`=0, `res_vec[127:64]` is zero.
- R7: `out_valid` is high exactly in the cycle after each cycle with `in_valid` high. `illegal_op` is low for legal size codes.
- R8: Without `in_valid`, `res_vec` and `illegal_op` hold their values even when the inputs change.
- R9: When the source and destination carry the same vector, accumulation uses that vector's original lane values.
- R10: After reset, `out_valid`, `illegal_op` and `res_vec` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src_vec | input | 128 | Source vector |
| dst_vec | input | 128 | Current destination vector |
| elem_size | input | 2 | Source element size code |
| wide_q | input | 1 | 1 = 128-bit operation, 0 = 64-bit operation |
| is_signed | input | 1 | 1 = sign extension, 0 = zero extension |
| do_accum | input | 1 | 1 = add destination lane |
| out_valid | output | 1 | Result valid, one cycle after request |
| res_vec | output | 128 | Registered result vector |
| illegal_op | output | 1 | Reserved size code seen |

## Verification
Random vectors sweep every combination of size, width, signedness and accumulate mode. They are compared against a lane loop in the bench, so a wrong pairing, a wrong extension or a wrong lane width shows up as a mismatch.

Directed vectors probe the points where the two extension modes part ways:
- All lanes at the most negative value and all lanes all-ones split signed handling from unsigned handling.
- All lanes at the maximum positive value exercise the carry out of the pair sum.
- All-ones accumulation forces wrap-around.

Passing the same vector as source and destination confirms that the original lane values feed the accumulation. Idle cycles with changed inputs confirm that the outputs hold.

// File: rtl/pwa_pkg.sv
package pwa_pkg;
  localparam int VEC_W   = 128;
  localparam int BASE_W  = 8;
  localparam int NUM_SZ  = 3;

  typedef enum logic [1:0] {
    SZ_B   = 2'd0,
    SZ_H   = 2'd1,
    SZ_W   = 2'd2,
    SZ_RSV = 2'd3
  } pwa_size_e;
endpackage

// File: rtl/pwa_pair_lanes.sv
// Pairwise widening adder for one fixed source element width.
module pwa_pair_lanes #(
  parameter int VEC_W = 128,
  parameter int SRC_W = 8
) (
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] dst_i,
  input  logic             sgn_i,
  input  logic             acc_i,
  output logic [VEC_W-1:0] sum_o
);
  localparam int DST_W = 2 * SRC_W;
  localparam int NPAIR = VEC_W / DST_W;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic [SRC_W-1:0] lo_e, hi_e;
    logic [DST_W-1:0] lo_x, hi_x, acc_x;

    assign lo_e  = src_i[(2*p)*SRC_W +: SRC_W];
    assign hi_e  = src_i[(2*p+1)*SRC_W +: SRC_W];
    // R4: extension chosen by signedness
    assign lo_x  = {{SRC_W{sgn_i & lo_e[SRC_W-1]}}, lo_e};
    assign hi_x  = {{SRC_W{sgn_i & hi_e[SRC_W-1]}}, hi_e};
    // R5/R9: accumulate reads the incoming destination lane only
    assign acc_x = acc_i ? dst_i[p*DST_W +: DST_W] : '0;
    assign sum_o[p*DST_W +: DST_W] = lo_x + hi_x + acc_x;
  end
endmodule

// File: rtl/pwa_result_sel.sv
// Picks the lane result for the size code, handles the reserved code and half width.
module pwa_result_sel #(
  parameter int VEC_W  = 128,
  parameter int NUM_SZ = 3
) (
  input  logic [NUM_SZ-1:0][VEC_W-1:0] cand_i,
  input  logic [1:0]                   size_i,
  input  logic                         q_i,
  input  logic [VEC_W-1:0]             dst_i,
  output logic [VEC_W-1:0]             res_o,
  output logic                         rsv_o
);
  localparam int HALF_W = VEC_W / 2;

  logic [VEC_W-1:0] picked;

  always_comb begin
    rsv_o  = 1'b1;
    picked = dst_i;
    for (int k = 0; k < NUM_SZ; k++) begin
      if (size_i == 2'(k)) begin
        rsv_o  = 1'b0;
        picked = cand_i[k];
      end
    end
    if (!rsv_o && !q_i) res_o = {{HALF_W{1'b0}}, picked[HALF_W-1:0]};
    else                res_o = picked;
  end
endmodule

// File: rtl/pairwise_widen_acc.sv
module pairwise_widen_acc #(
  parameter int VEC_W  = pwa_pkg::VEC_W,
  parameter int BASE_W = pwa_pkg::BASE_W,
  parameter int NUM_SZ = pwa_pkg::NUM_SZ
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] dst_vec,
  input  logic [1:0]       elem_size,
  input  logic             wide_q,
  input  logic             is_signed,
  input  logic             do_accum,
  output logic             out_valid,
  output logic [VEC_W-1:0] res_vec,
  output logic             illegal_op
);
  localparam int HALF_W = VEC_W / 2;

  logic [NUM_SZ-1:0][VEC_W-1:0] cand;
  logic [VEC_W-1:0]             next_res;
  logic                         next_rsv;

  for (genvar s = 0; s < NUM_SZ; s++) begin : g_size
    pwa_pair_lanes #(
      .VEC_W (VEC_W),
      .SRC_W (BASE_W << s)
    ) u_lanes (
      .src_i (src_vec),
      .dst_i (dst_vec),
      .sgn_i (is_signed),
      .acc_i (do_accum),
      .sum_o (cand[s])
    );
  end

  pwa_result_sel #(
    .VEC_W  (VEC_W),
    .NUM_SZ (NUM_SZ)
  ) u_sel (
    .cand_i (cand),
    .size_i (elem_size),
    .q_i    (wide_q),
    .dst_i  (dst_vec),
    .res_o  (next_res),
    .rsv_o  (next_rsv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      res_vec    <= '0;
      illegal_op <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_vec    <= next_res;
        illegal_op <= next_rsv;
      end
    end
  end

  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_legal_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && elem_size != 2'd3) |=> !illegal_op);
  p_reserved_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && elem_size == 2'd3) |=> (illegal_op && res_vec == $past(dst_vec)));
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_q && elem_size != 2'd3) |=> (res_vec[VEC_W-1:HALF_W] == '0));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res_vec) && $stable(illegal_op)));
endmodule

// File: tb/test_pairwise_widen_acc.sv
module test_pairwise_widen_acc;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] src_vec = '0, dst_vec = '0;
  logic [1:0]   elem_size = '0;
  logic         wide_q = 1'b0, is_signed = 1'b0, do_accum = 1'b0;
  logic         out_valid, illegal_op;
  logic [127:0] res_vec;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pairwise_widen_acc i_pairwise_widen_acc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec), .dst_vec(dst_vec),
    .elem_size(elem_size), .wide_q(wide_q), .is_signed(is_signed), .do_accum(do_accum),
    .out_valid(out_valid), .res_vec(res_vec), .illegal_op(illegal_op)
  );

  function automatic logic [127:0] ref_op(input logic [127:0] s, input logic [127:0] d,
                                          input logic [1:0] sz, input logic q,
                                          input logic sg, input logic ac);
    logic [127:0] r;
    logic [63:0] m1, m2, a, b, c, t;
    int esz, nel;
    if (sz == 2'd3) return d;
    esz = 8 << sz;
    nel = (q ? 128 : 64) / (2 * esz);
    m1 = (64'd1 << esz) - 64'd1;
    m2 = (esz == 32) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (2 * esz)) - 64'd1);
    r = '0;
    for (int e = 0; e < nel; e++) begin
      a = 64'(s >> (2 * e * esz)) & m1;
      b = 64'(s >> ((2 * e + 1) * esz)) & m1;
      if (sg && a[esz-1]) a = a | ~m1;
      if (sg && b[esz-1]) b = b | ~m1;
      c = ac ? (64'(d >> (e * 2 * esz)) & m2) : 64'd0;
      t = (a + b + c) & m2;
      r = r | (128'(t) << (e * 2 * esz));
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drives one request and checks the result one cycle later.
  task automatic run_op(input string tag, input logic [127:0] s, input logic [127:0] d,
                        input logic [1:0] sz, input logic q, input logic sg, input logic ac);
    @(negedge clk);
    src_vec = s; dst_vec = d; elem_size = sz; wide_q = q; is_signed = sg; do_accum = ac;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R7 out_valid"}, 128'(out_valid), 128'd1);
    check({tag, " R7/R2 illegal_op"}, 128'(illegal_op), 128'(sz == 2'd3));
    check({tag, " result"}, res_vec, ref_op(s, d, sz, q, sg, ac));
  endtask

  initial begin
    logic [127:0] held;
    logic         held_ill;
    logic [127:0] v;
    logic [127:0] w;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10
    check("R10 out_valid", 128'(out_valid), 128'd0);
    check("R10 illegal_op", 128'(illegal_op), 128'd0);
    check("R10 res_vec", res_vec, 128'd0);

    // R1 R4: hand-worked values
    run_op("R1 R4 byte signed", {112'd0, 8'hFF, 8'h01}, '0, 2'd0, 1'b1, 1'b1, 1'b0);
    check("R4 signed -1+1", res_vec[15:0], 16'h0000);
    run_op("R1 R4 byte unsigned", {112'd0, 8'hFF, 8'h01}, '0, 2'd0, 1'b1, 1'b0, 1'b0);
    check("R4 unsigned 255+1", res_vec[15:0], 16'h0100);
    run_op("R1 word signed", {64'd0, 32'h8000_0000, 32'h8000_0000}, '0, 2'd2, 1'b1, 1'b1, 1'b0);
    check("R1 64-bit lane", res_vec[63:0], 64'hFFFF_FFFF_0000_0000);

    // Corner vectors: max positive, most negative, all ones
    for (int sz = 0; sz < 3; sz++) begin
      for (int k = 0; k < 8; k++) begin
        int qq = k & 1;
        int sg = (k >> 1) & 1;
        int ac = (k >> 2) & 1;
        w = '0;
        for (int i = 0; i < 16; i++) w[i*8 +: 8] = 8'h7F;
        if (sz == 1) for (int i = 0; i < 8; i++) w[i*16 +: 16] = 16'h7FFF;
        if (sz == 2) for (int i = 0; i < 4; i++) w[i*32 +: 32] = 32'h7FFF_FFFF;
        run_op("R4 R5 maxpos", w, w, 2'(sz), 1'(qq), 1'(sg), 1'(ac));
        run_op("R4 R5 mostneg", ~w, ~w, 2'(sz), 1'(qq), 1'(sg), 1'(ac));
        run_op("R5 allones wrap", '1, '1, 2'(sz), 1'(qq), 1'(sg), 1'(ac));
      end
    end

    // R9: same vector as source and destination
    v = {$urandom, $urandom, $urandom, $urandom};
    run_op("R9 aliased", v, v, 2'd1, 1'b1, 1'b1, 1'b1);
    check("R9 lane0", res_vec[31:0],
          32'({{16{v[15]}}, v[15:0]} + {{16{v[31]}}, v[31:16]} + v[31:0]));

    // R6 R3: half width
    run_op("R3 R6 half", '1, '1, 2'd0, 1'b0, 1'b0, 1'b1);
    check("R6 upper zero", res_vec[127:64], 64'd0);

    // R2: reserved code
    v = {$urandom, $urandom, $urandom, $urandom};
    run_op("R2 reserved", '1, v, 2'd3, 1'b0, 1'b1, 1'b1);
    check("R2 dst passthrough", res_vec, v);

    // R8: hold while idle
    run_op("R8 setup", {$urandom, $urandom, $urandom, $urandom}, '0, 2'd1, 1'b1, 1'b0, 1'b0);
    held = res_vec;
    held_ill = illegal_op;
    @(negedge clk);
    src_vec = ~src_vec; dst_vec = '1; elem_size = 2'd3;
    @(negedge clk);
    @(negedge clk);
    check("R8 hold res", res_vec, held);
    check("R8 hold illegal", 128'(illegal_op), 128'(held_ill));
    check("R8 R7 out_valid low", 128'(out_valid), 128'd0);

    // Random sweep
    for (int n = 0; n < 400; n++) begin
      run_op("R1 R3 R4 R5 random",
             {$urandom, $urandom, $urandom, $urandom},
             {$urandom, $urandom, $urandom, $urandom},
             2'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    // Back-to-back requests: R7
    @(negedge clk);
    in_valid = 1'b1; elem_size = 2'd0; wide_q = 1'b1; is_signed = 1'b0; do_accum = 1'b0;
    src_vec = '1; dst_vec = '0;
    @(negedge clk);
    check("R7 b2b first", res_vec, ref_op('1, '0, 2'd0, 1'b1, 1'b0, 1'b0));
    src_vec = '0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 b2b second", res_vec, 128'd0);
    check("R7 b2b valid", 128'(out_valid), 128'd1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule